// File: doc/BRIEF.md
# Two-Digit Decimal Up/Down Counter

This block is a synchronous decimal counter made of cascaded binary-coded-decimal digit stages. With the default parameters it has two digits and runs through 00 to 99. It wraps around in both directions: up from 99 to 00, and down from 00 to 99. Each digit stage holds one value from 0 to 9 and steps it when that stage is enabled. The enable of a higher digit is formed combinationally from the count enable and from the terminal state of every lower digit. A lower digit is in its terminal state when it holds 9 while counting up, or 0 while counting down. Because of this, the tens digit changes on the same clock edge as the ones digit's rollover and never lags one count behind.

The counter has an asynchronous active-high clear, a synchronous parallel load of all digits, a count enable and a direction select. The count output is packed with the most significant digit in the highest nibble. A terminal flag reports, before the edge, that the next enabled step wraps the whole counter. The load value is assumed to be valid BCD.

Top module: `dec_updown_counter`

## Requirements
- R1: While `arst_i` is 1 the count is 0x00 at once, without waiting for a clock edge.
- R2: When `load_i` is 1 at a rising edge, the count takes `load_val_i` on that edge, whatever the values of `cnt_en_i` and `dir_i`.
- R3: With `dir_i`=0 (up) and enable high, a ones digit of 9 becomes 0 and the tens digit rises by one on the same edge (for example 09 becomes 10, not 00).
- R4: With `dir_i`=1 (down) and enable high, a ones digit of 0 becomes 9 and the tens digit falls by one on the same edge (for example 10 becomes 09).
- R5: Counting up from 99, the next value is 00. `term_o` is 1 during the cycle in which the count is 99 and enable is high.
- R6: Counting down from 00, the next value is 99. `term_o` is 1 during the cycle in which the count is 00 and enable is high.
- R7: When `cnt_en_i` is 0 and no load occurs, the count holds and `term_o` is 0.
- R8: The count is packed with the tens digit in bits [7:4] and the ones digit in bits [3:0]. Every enabled step moves the decimal value by exactly one modulo 100, in the direction `dir_i` selects. This holds for every start value and across a change of direction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| arst_i | input | 1 | Asynchronous clear, active high |
| load_i | input | 1 | Synchronous parallel load; takes priority over counting |
| load_val_i | input | 8 | Packed BCD value to load (tens in [7:4]) |
| cnt_en_i | input | 1 | Count enable |
| dir_i | input | 1 | Direction: 0 counts up, 1 counts down |
| count_o | output | 8 | Packed BCD count (tens in [7:4], ones in [3:0]) |
| term_o | output | 1 | High when the next enabled step wraps the whole counter |

## Verification
Short runs start from loaded values 08, 11, 98 and 01. These separate a correct same-edge carry from a one-count-late carry, since the late version produces 09→00→11 instead of 09→10→11. The same runs expose a wrap that skips or repeats a value. Full sweeps of 250 steps up and then down are compared against a modulo-100 reference model. These catch wrong nibble packing and a direction change that upsets the count. Loads with enable high, and disabled stretches at 39 and 99, show that load priority and holding keep the count and the terminal flag where the requirements put them.

// File: rtl/dcnt_pkg.sv
package dcnt_pkg;
   localparam int unsigned BCD_W = 4;
   typedef logic [BCD_W-1:0] bcd_t;
   localparam bcd_t BCD_TOP    = 4'd9;
   localparam bcd_t BCD_BOTTOM = 4'd0;
   typedef enum logic {DIR_UP = 1'b0, DIR_DOWN = 1'b1} dir_e;
endpackage

// File: rtl/dcnt_digit_step.sv
// Next-value and terminal-state logic for one decimal digit.
module dcnt_digit_step
   import dcnt_pkg::*;
(
   input  bcd_t cur_i,
   input  dir_e dir_i,
   output bcd_t nxt_o,
   output logic at_edge_o
);
   always_comb begin
      if (dir_i == DIR_DOWN) begin
         at_edge_o = (cur_i == BCD_BOTTOM);
         nxt_o     = at_edge_o ? BCD_TOP : cur_i - 4'd1;
      end else begin
         at_edge_o = (cur_i == BCD_TOP);
         nxt_o     = at_edge_o ? BCD_BOTTOM : cur_i + 4'd1;
      end
   end
endmodule

// File: rtl/dcnt_digit_stage.sv
// One registered decimal digit with load priority over counting.
module dcnt_digit_stage
   import dcnt_pkg::*;
(
   input  logic clk_i,
   input  logic arst_i,
   input  logic load_i,
   input  bcd_t load_val_i,
   input  logic en_i,
   input  dir_e dir_i,
   output bcd_t q_o,
   output logic at_edge_o
);
   bcd_t digit_q;
   bcd_t digit_nxt;

   dcnt_digit_step u_step (
      .cur_i     (digit_q),
      .dir_i     (dir_i),
      .nxt_o     (digit_nxt),
      .at_edge_o (at_edge_o)
   );

   always_ff @(posedge clk_i or posedge arst_i) begin
      if (arst_i)      digit_q <= BCD_BOTTOM;
      else if (load_i) digit_q <= load_val_i;
      else if (en_i)   digit_q <= digit_nxt;
   end

   assign q_o = digit_q;
endmodule

// File: rtl/dec_updown_counter.sv
// Cascaded decimal counter; higher digits are enabled in the same cycle
// as the lower rollover, never from a registered carry.
module dec_updown_counter
   import dcnt_pkg::*;
#(
   parameter int unsigned NUM_DIGITS = 2,
   parameter bit          LOOKAHEAD  = 1'b1
) (
   input  logic                        clk_i,
   input  logic                        arst_i,
   input  logic                        load_i,
   input  logic [4*NUM_DIGITS-1:0]     load_val_i,
   input  logic                        cnt_en_i,
   input  logic                        dir_i,
   output logic [4*NUM_DIGITS-1:0]     count_o,
   output logic                        term_o
);
   localparam int unsigned TOTAL_W = BCD_W * NUM_DIGITS;

   if (NUM_DIGITS < 1 || NUM_DIGITS > 8) begin : g_bad_digits
      $error("dec_updown_counter: NUM_DIGITS must be 1..8");
   end
   if (TOTAL_W != 4 * NUM_DIGITS) begin : g_bad_width
      $error("dec_updown_counter: digit width must be 4");
   end

   dir_e                  dir_sel;
   logic [NUM_DIGITS-1:0] stage_en;
   logic [NUM_DIGITS-1:0] stage_edge;

   assign dir_sel     = dir_e'(dir_i);
   assign stage_en[0] = cnt_en_i;

   for (genvar k = 0; k < NUM_DIGITS; k++) begin : g_digit
      dcnt_digit_stage u_stage (
         .clk_i      (clk_i),
         .arst_i     (arst_i),
         .load_i     (load_i),
         .load_val_i (load_val_i[k*BCD_W +: BCD_W]),
         .en_i       (stage_en[k]),
         .dir_i      (dir_sel),
         .q_o        (count_o[k*BCD_W +: BCD_W]),
         .at_edge_o  (stage_edge[k])
      );
      if (k > 0) begin : g_en
         if (LOOKAHEAD) begin : g_look
            assign stage_en[k] = cnt_en_i & (&stage_edge[k-1:0]);
         end else begin : g_ripple
            assign stage_en[k] = stage_en[k-1] & stage_edge[k-1];
         end
      end
   end

   assign term_o = stage_en[NUM_DIGITS-1] & stage_edge[NUM_DIGITS-1];
endmodule

// File: rtl/dcnt_checker.sv
module dcnt_checker #(
   parameter int unsigned NUM_DIGITS = 2
) (
   input logic                    clk_i,
   input logic                    arst_i,
   input logic                    load_i,
   input logic [4*NUM_DIGITS-1:0] load_val_i,
   input logic                    cnt_en_i,
   input logic                    dir_i,
   input logic [4*NUM_DIGITS-1:0] count_o,
   input logic                    term_o
);
   localparam logic [4*NUM_DIGITS-1:0] ALL_NINE = {NUM_DIGITS{4'h9}};

   a_r1_clear: assert property (@(posedge clk_i) arst_i |-> count_o == '0);

   a_r2_load: assert property (@(posedge clk_i) disable iff (arst_i)
      load_i |=> count_o == $past(load_val_i));

   a_r5_wrap_up: assert property (@(posedge clk_i) disable iff (arst_i)
      (!load_i && cnt_en_i && !dir_i && count_o == ALL_NINE) |=> count_o == '0);

   a_r6_wrap_down: assert property (@(posedge clk_i) disable iff (arst_i)
      (!load_i && cnt_en_i && dir_i && count_o == '0) |=> count_o == ALL_NINE);

   a_r5_term_src: assert property (@(posedge clk_i) disable iff (arst_i)
      term_o |-> (cnt_en_i && ((!dir_i && count_o == ALL_NINE) || (dir_i && count_o == '0))));

   a_r7_hold: assert property (@(posedge clk_i) disable iff (arst_i)
      (!load_i && !cnt_en_i) |=> $stable(count_o));

   a_r7_term_low: assert property (@(posedge clk_i) disable iff (arst_i)
      !cnt_en_i |-> !term_o);

   if (NUM_DIGITS >= 2) begin : g_two
      a_r3_same_edge_carry: assert property (@(posedge clk_i) disable iff (arst_i)
         (!load_i && cnt_en_i && !dir_i && count_o[3:0] == 4'h9 && count_o[7:4] != 4'h9)
         |=> (count_o[3:0] == 4'h0 && count_o[7:4] == $past(count_o[7:4]) + 4'h1));
      a_r4_same_edge_borrow: assert property (@(posedge clk_i) disable iff (arst_i)
         (!load_i && cnt_en_i && dir_i && count_o[3:0] == 4'h0 && count_o[7:4] != 4'h0)
         |=> (count_o[3:0] == 4'h9 && count_o[7:4] == $past(count_o[7:4]) - 4'h1));
   end
endmodule

bind dec_updown_counter dcnt_checker #(.NUM_DIGITS(NUM_DIGITS)) u_dcnt_chk (
   .clk_i      (clk_i),
   .arst_i     (arst_i),
   .load_i     (load_i),
   .load_val_i (load_val_i),
   .cnt_en_i   (cnt_en_i),
   .dir_i      (dir_i),
   .count_o    (count_o),
   .term_o     (term_o)
);

// File: tb/dec_updown_counter_tb.sv
`timescale 1ns/1ps
module dec_updown_counter_tb_top;
   logic       clk = 1'b0;
   logic       arst = 1'b1;
   logic       load = 1'b0;
   logic [7:0] load_val = 8'h00;
   logic       en = 1'b0;
   logic       dir = 1'b0;
   logic [7:0] count;
   logic       term;
   int n_checks = 0;
   int n_fail   = 0;

   always #2 clk = ~clk;

   dec_updown_counter dut_i (
      .clk_i(clk), .arst_i(arst), .load_i(load), .load_val_i(load_val),
      .cnt_en_i(en), .dir_i(dir), .count_o(count), .term_o(term)
   );

   function automatic logic [7:0] to_bcd(input int v);
      return {4'(v / 10), 4'(v % 10)};
   endfunction

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk); @(negedge clk);
   endtask

   task automatic do_load(input logic [7:0] v);
      load = 1'b1; load_val = v;
      step();
      load = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1 reset count", count, 8'h00);
      chk("R1 reset term", {7'b0, term}, 8'h00);
      arst = 1'b0;
      step();
      do_load(8'h57);
      #0.5 arst = 1'b1;
      #0.5 chk("R1 async clear", count, 8'h00);
      @(negedge clk); arst = 1'b0;
      step();
   endtask

   task automatic t_load();
      en = 1'b0;
      do_load(8'h42);
      chk("R2 load value", count, 8'h42);
      do_load(8'h10);
      en = 1'b1; dir = 1'b0;
      do_load(8'h73);
      chk("R2 load over up count", count, 8'h73);
      dir = 1'b1;
      do_load(8'h05);
      chk("R2 load over down count", count, 8'h05);
      en = 1'b0;
   endtask

   task automatic t_up_carry();
      en = 1'b0; do_load(8'h08);
      en = 1'b1; dir = 1'b0;
      step(); chk("R3 up 09", count, 8'h09);
      step(); chk("R3 up carry 10", count, 8'h10);
      step(); chk("R3 up 11", count, 8'h11);
      en = 1'b0;
   endtask

   task automatic t_down_borrow();
      en = 1'b0; do_load(8'h11);
      en = 1'b1; dir = 1'b1;
      step(); chk("R4 down 10", count, 8'h10);
      step(); chk("R4 down borrow 09", count, 8'h09);
      step(); chk("R4 down 08", count, 8'h08);
      en = 1'b0;
   endtask

   task automatic t_wrap_up();
      en = 1'b0; do_load(8'h98);
      en = 1'b1; dir = 1'b0;
      chk("R5 term low at 98", {7'b0, term}, 8'h00);
      step(); chk("R5 at 99", count, 8'h99);
      chk("R5 term high at 99", {7'b0, term}, 8'h01);
      step(); chk("R5 wrap to 00", count, 8'h00);
      chk("R5 term low at 00 up", {7'b0, term}, 8'h00);
      en = 1'b0;
   endtask

   task automatic t_wrap_down();
      en = 1'b0; do_load(8'h01);
      en = 1'b1; dir = 1'b1;
      chk("R6 term low at 01", {7'b0, term}, 8'h00);
      step(); chk("R6 at 00", count, 8'h00);
      chk("R6 term high at 00", {7'b0, term}, 8'h01);
      step(); chk("R6 wrap to 99", count, 8'h99);
      chk("R6 term low at 99 down", {7'b0, term}, 8'h00);
      en = 1'b0;
   endtask

   task automatic t_hold();
      en = 1'b0; do_load(8'h39);
      dir = 1'b0;
      for (int i = 0; i < 4; i++) step();
      chk("R7 hold 39", count, 8'h39);
      do_load(8'h99);
      chk("R7 term low disabled at 99", {7'b0, term}, 8'h00);
      step(); chk("R7 hold 99", count, 8'h99);
      do_load(8'h00); dir = 1'b1;
      chk("R7 term low disabled at 00", {7'b0, term}, 8'h00);
      step(); chk("R7 hold 00", count, 8'h00);
   endtask

   task automatic t_sweep();
      int model = 37;
      int errs  = 0;
      en = 1'b0; do_load(to_bcd(model));
      chk("R8 packing of load", count, 8'h37);
      en = 1'b1; dir = 1'b0;
      for (int i = 0; i < 250; i++) begin
         step(); model = (model + 1) % 100;
         if (count !== to_bcd(model)) begin
            errs++;
            if (errs == 1) chk("R8 up sweep", count, to_bcd(model));
         end
      end
      dir = 1'b1;
      for (int i = 0; i < 250; i++) begin
         step(); model = (model + 99) % 100;
         if (count !== to_bcd(model)) begin
            errs++;
            if (errs == 1) chk("R8 down sweep", count, to_bcd(model));
         end
      end
      if (errs == 0) chk("R8 sweep final", count, to_bcd(model));
      en = 1'b0;
   endtask

   initial begin
      @(negedge clk); @(negedge clk);
      t_reset();
      t_load();
      t_up_carry();
      t_down_borrow();
      t_wrap_up();
      t_wrap_down();
      t_hold();
      t_sweep();
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end
endmodule